// File: doc/BRIEF.md
# Windowed Clock Frequency Counter

The block measures the frequency of one of several internal clocks. Software selects a source and a window length, given as a count of reference-clock cycles. The block then counts rising edges of the selected clock for exactly that many reference cycles. With a 2700-cycle window on a 27 MHz reference the window lasts 100 µs, so the count multiplied by ten gives the frequency in kHz. The block holds the result and makes it readable on a simple register bus.

Three clock domains are involved:
- **Bus domain.** It holds the control register, the arm flag and the count register that software reads.
- **Reference domain.** A window state machine runs here. Its states are IDLE, RUN and HOLD:
  - IDLE goes to RUN when the synchronized arm flag is seen.
  - RUN goes to HOLD after the programmed number of cycles. RUN goes to IDLE if the arm flag is lost.
  - HOLD goes to IDLE when the arm flag drops.
- **Measured-clock domain.** An edge-counting state machine runs here. Its states are CLEAR, COUNT and FROZEN:
  - CLEAR goes to COUNT when the synchronized gate rises.
  - COUNT goes to FROZEN when the gate falls.
  - Dropping the arm flag forces the state back to CLEAR through an asynchronous clear. This clear works even if the selected clock is not toggling.

The frozen count is stable before its done flag crosses into the bus domain through two flops. The bus domain captures the count on the rising edge of that synchronized flag.

The sequence software uses is fixed:
1. Write the counter-reset bit high with enable low.
2. Check that the count reads zero.
3. In one write, set enable and write-enable, give the window and the source, and leave the counter-reset bit low.
4. Read the count once the window has elapsed.
5. Afterwards, assert the counter-reset bit again and write back the previously read control value.

Top module: `clk_meter`

## Requirements
- R1: A measurement gates counting for exactly the programmed window of reference cycles, taken from control bits [15:0]. The captured count equals the window times the ratio of measured to reference frequency, within one edge.
- R2: The window (bits [15:0]) and source (bits [31:28]) fields are updated only by a control write with bit 16 equal to 1. A write with bit 16 equal to 0 leaves both fields unchanged, as seen in the control readback.
- R3: Enable is bit 20. A write with bit 16 set and bit 20 clear starts no measurement. Any write with bit 20 clear stops an armed measurement, and the count stays zero.
- R4: Counter reset is bit 24. A write with this bit set clears the count register to zero on the next cycle, and the count stays zero while the bit remains set.
- R5: Source code 0x0 selects meas_clk[0], code 0x2 selects meas_clk[1] and code 0x7 selects meas_clk[2]. Any other code selects no clock, and a measurement with such a code leaves the count at zero.
- R6: A measurement is armed only by a write with bit 16 = 1, bit 20 = 1, bit 24 = 0 and a nonzero window. Writing back a read control value (which always has bit 16 = 0) after a reset never starts a measurement.
- R7: A write with a window of zero arms nothing, and the count register stays zero.
- R8: After the window ends, the count register keeps its final value until the next counter reset, including across later writes with bit 16 = 0.
- R9: If the number of edges exceeds the counter width, the count saturates at 2^CNT_W-1 instead of wrapping.
- R10: Reading address 0 returns the control value with these fields:
  - window in bits [15:0];
  - 0 in bit 16;
  - enable in bit 20;
  - reset in bit 24;
  - source in bits [31:28];
  - 0 in all other bits.

  Reading address 1 returns the count, zero-extended. After reset both reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Register bus clock |
| bus_rst_n | input | 1 | Active-low asynchronous reset for all domains |
| bus_wr | input | 1 | Write strobe, sampled on bus_clk |
| bus_addr | input | 1 | Register select: 0 control, 1 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ref_clk | input | 1 | Reference clock that times the window |
| meas_clk | input | NUM_SRC | Candidate clocks to be measured |

## Verification
The assertions assume that the window field is not rewritten while a measurement is armed. They also assume that the source field changes only while the counter is held in reset or not yet armed, so the selected clock never switches in the middle of a window. The stimulus always asserts the counter-reset bit and waits several reference cycles before each new arming write. It changes the window and source only inside that arming write. The measured clocks are offset from the reference edges by a fraction of a nanosecond, so synchronizer sampling does not depend on the order of events at coincident edges.

// File: rtl/clkm_pkg.sv
package clkm_pkg;

    localparam int NSRC      = 3;
    localparam int WIN_W     = 16;
    localparam int SRC_W     = 4;
    localparam int BIT_WE    = 16;
    localparam int BIT_EN    = 20;
    localparam int BIT_RST   = 24;
    localparam int SRC_LSB   = 28;

    typedef enum logic [1:0] {
        R_IDLE = 2'd0,
        R_RUN  = 2'd1,
        R_HOLD = 2'd2
    } ref_state_t;

    typedef enum logic [1:0] {
        M_CLEAR  = 2'd0,
        M_COUNT  = 2'd1,
        M_FROZEN = 2'd2
    } meas_state_t;

    function automatic logic [NSRC-1:0] src_onehot(input logic [SRC_W-1:0] code);
        logic [NSRC-1:0] oh;
        oh = '0;
        unique case (code)
            4'h0:    oh[0] = 1'b1;
            4'h2:    oh[1] = 1'b1;
            4'h7:    oh[2] = 1'b1;
            default: oh = '0;
        endcase
        return oh;
    endfunction

endpackage

// File: rtl/clkm_sync.sv
module clkm_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= '0;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/clkm_window.sv
module clkm_window
    import clkm_pkg::*;
#(
    parameter int WIN_BITS = WIN_W
) (
    input  logic                ref_clk,
    input  logic                rst_n,
    input  logic                arm_async,
    input  logic [WIN_BITS-1:0] window,
    output logic                gate
);
    logic                arm_r;
    ref_state_t          state_q, state_d;
    logic [WIN_BITS-1:0] left_q;
    logic [WIN_BITS-1:0] run_len_q;

    clkm_sync #(.W(1), .STAGES(2)) u_arm_sync (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .d    (arm_async),
        .q    (arm_r)
    );

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) state_q <= R_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            R_IDLE: if (arm_r) state_d = R_RUN;
            R_RUN: begin
                if (!arm_r)            state_d = R_IDLE;
                else if (left_q == '0) state_d = R_HOLD;
            end
            R_HOLD: if (!arm_r) state_d = R_IDLE;
            default: state_d = R_IDLE;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            left_q    <= '0;
            run_len_q <= '0;
        end else begin
            if (state_q == R_IDLE)     left_q <= window - 1'b1;
            else if (state_q == R_RUN) left_q <= left_q - 1'b1;
            if (state_q == R_RUN) run_len_q <= run_len_q + 1'b1;
            else                  run_len_q <= '0;
        end
    end

    always_comb begin
        gate = (state_q == R_RUN);
    end

    AST_WINDOW_LEN: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (state_q == R_RUN) |-> (run_len_q < window)); // R1

endmodule

// File: rtl/clkm_edge_counter.sv
module clkm_edge_counter
    import clkm_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             mclk,
    input  logic             clr_n,
    input  logic             gate_async,
    output logic [CNT_W-1:0] cnt,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [1:0]       rst_chain;
    logic             mrst_n;
    logic             gate_m;
    meas_state_t      state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge mclk or negedge clr_n) begin
        if (!clr_n) rst_chain <= 2'b00;
        else        rst_chain <= {rst_chain[0], 1'b1};
    end
    assign mrst_n = rst_chain[1];

    clkm_sync #(.W(1), .STAGES(2)) u_gate_sync (
        .clk  (mclk),
        .rst_n(mrst_n),
        .d    (gate_async),
        .q    (gate_m)
    );

    always_ff @(posedge mclk or negedge mrst_n) begin
        if (!mrst_n) state_q <= M_CLEAR;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            M_CLEAR:  if (gate_m)  state_d = M_COUNT;
            M_COUNT:  if (!gate_m) state_d = M_FROZEN;
            M_FROZEN: state_d = M_FROZEN;
            default:  state_d = M_CLEAR;
        endcase
    end

    always_ff @(posedge mclk or negedge mrst_n) begin
        if (!mrst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                M_CLEAR:  if (gate_m) cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
                M_COUNT:  if (gate_m && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
                default:  cnt_q <= cnt_q;
            endcase
        end
    end

    always_comb begin
        cnt  = cnt_q;
        done = (state_q == M_FROZEN);
    end

    AST_FROZEN_STABLE: assert property (@(posedge mclk) disable iff (!mrst_n)
        (state_q == M_FROZEN) |=> $stable(cnt_q)); // R8

    AST_SATURATE: assert property (@(posedge mclk) disable iff (!mrst_n)
        (state_q == M_COUNT && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R9

endmodule

// File: rtl/clkm_bus_regs.sv
module clkm_bus_regs
    import clkm_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic             done_async,
    input  logic [CNT_W-1:0] cnt_async,
    output logic             arm,
    output logic [WIN_W-1:0] window,
    output logic [SRC_W-1:0] src
);
    logic             en_q, rst_q, arm_q;
    logic [WIN_W-1:0] win_q;
    logic [SRC_W-1:0] src_q;
    logic [CNT_W-1:0] count_q;
    logic             done_b, done_b_q;
    logic             ctrl_wr, w_we, w_en, w_rst;
    logic [WIN_W-1:0] w_win;
    logic             unused_bits;

    assign ctrl_wr = wr && !addr;
    assign w_we    = wdata[BIT_WE];
    assign w_en    = wdata[BIT_EN];
    assign w_rst   = wdata[BIT_RST];
    assign w_win   = wdata[WIN_W-1:0];
    assign unused_bits = ^{wdata[27:25], wdata[23:21], wdata[19:17]};

    clkm_sync #(.W(1), .STAGES(2)) u_done_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (done_async),
        .q    (done_b)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q     <= 1'b0;
            rst_q    <= 1'b0;
            arm_q    <= 1'b0;
            win_q    <= '0;
            src_q    <= '0;
            count_q  <= '0;
            done_b_q <= 1'b0;
        end else begin
            done_b_q <= done_b;
            if (ctrl_wr) begin
                en_q  <= w_en;
                rst_q <= w_rst;
                if (w_we) begin
                    win_q <= w_win;
                    src_q <= wdata[SRC_LSB +: SRC_W];
                    arm_q <= arm_q || (w_en && !w_rst && w_win != '0);
                    if (!w_en || w_rst || w_win == '0) arm_q <= 1'b0;
                end else begin
                    arm_q <= arm_q && w_en && !w_rst;
                end
            end
            if (ctrl_wr && w_rst) begin
                count_q <= '0;
            end else if (!rst_q && arm_q && done_b && !done_b_q) begin
                count_q <= cnt_async;
            end
        end
    end

    always_comb begin
        if (addr) rdata = {{(32-CNT_W){1'b0}}, count_q};
        else      rdata = {src_q, 3'b000, rst_q, 3'b000, en_q, 3'b000, 1'b0, win_q};
    end

    assign arm    = arm_q;
    assign window = win_q;
    assign src    = src_q;

    AST_RESET_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && w_rst) |=> (count_q == '0)); // R4

    AST_NO_SPURIOUS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !w_we && !arm_q) |=> !arm_q); // R6

    AST_ZERO_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && w_we && w_win == '0) |=> !arm_q); // R7

    AST_EN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && !w_en) |=> !arm_q); // R3

endmodule

// File: rtl/clk_meter.sv
module clk_meter
    import clkm_pkg::*;
#(
    parameter int NUM_SRC = NSRC,
    parameter int CNT_W   = 20
) (
    input  logic               bus_clk,
    input  logic               bus_rst_n,
    input  logic               bus_wr,
    input  logic               bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               ref_clk,
    input  logic [NUM_SRC-1:0] meas_clk
);
    logic               arm;
    logic [WIN_W-1:0]   window;
    logic [SRC_W-1:0]   src;
    logic               gate;
    logic               done;
    logic [CNT_W-1:0]   cnt;
    logic [NSRC-1:0]    sel_oh;
    logic [NUM_SRC-1:0] gated;
    logic               mclk;
    logic               clr_n;

    assign sel_oh = src_onehot(src);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < NSRC) begin : g_map
            assign gated[i] = meas_clk[i] & sel_oh[i];
        end else begin : g_none
            assign gated[i] = 1'b0 & meas_clk[i];
        end
    end

    assign mclk  = |gated;
    assign clr_n = bus_rst_n & arm;

    clkm_bus_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (bus_clk),
        .rst_n     (bus_rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .rdata     (bus_rdata),
        .done_async(done),
        .cnt_async (cnt),
        .arm       (arm),
        .window    (window),
        .src       (src)
    );

    clkm_window #(.WIN_BITS(WIN_W)) u_window (
        .ref_clk  (ref_clk),
        .rst_n    (bus_rst_n),
        .arm_async(arm),
        .window   (window),
        .gate     (gate)
    );

    clkm_edge_counter #(.CNT_W(CNT_W)) u_count (
        .mclk      (mclk),
        .clr_n     (clr_n),
        .gate_async(gate),
        .cnt       (cnt),
        .done      (done)
    );

endmodule

// File: tb/clk_meter_test.sv
`timescale 1ns/1ps
module clk_meter_test;
    localparam int CW = 14;

    logic        bus_clk = 1'b0;
    logic        bus_rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_addr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_clk = 1'b0;
    logic [2:0]  meas_clk = 3'b000;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    clk_meter #(.NUM_SRC(3), .CNT_W(CW)) uut (
        .bus_clk  (bus_clk),
        .bus_rst_n(bus_rst_n),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ref_clk  (ref_clk),
        .meas_clk (meas_clk)
    );

    always #10 bus_clk = ~bus_clk;          // 50 MHz bus
    always #15 ref_clk = ~ref_clk;          // 30 ns reference
    initial begin #0.3; forever #7.5  meas_clk[0] = ~meas_clk[0]; end // ratio 2
    initial begin #0.3; forever #5.0  meas_clk[1] = ~meas_clk[1]; end // ratio 3
    initial begin #0.3; forever #3.75 meas_clk[2] = ~meas_clk[2]; end // ratio 4

    function automatic logic [31:0] ctl(input bit we, input bit en, input bit rs,
                                        input logic [3:0] s, input logic [15:0] w);
        return {s, 3'b0, rs, 3'b0, en, 3'b0, we, w};
    endfunction

    task automatic bus_write(input logic [31:0] d);
        @(negedge bus_clk);
        bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = d;
        @(negedge bus_clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge bus_clk);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic check_range(input string req, input string what,
                               input logic [31:0] act, input longint lo, input longint hi);
        checks++;
        if (longint'(act) < lo || longint'(act) > hi) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic check_eq(input string req, input string what,
                            input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(posedge bus_clk);
    endtask

    task automatic clear_counter();
        logic [31:0] d;
        bus_write(ctl(0, 0, 1, 4'h0, 16'h0));
        wait_cycles(20);
        bus_read(1'b1, d);
        check_eq("R4", "count during reset", d, 32'h0);
    endtask

    task automatic run_meas(input logic [3:0] s, input logic [15:0] w, output logic [31:0] d);
        clear_counter();
        bus_write(ctl(1, 1, 0, s, w));
        wait_cycles((int'(w) * 3) / 2 + 60);
        bus_read(1'b1, d);
    endtask

    task automatic t_reset_state();
        logic [31:0] d;
        bus_read(1'b0, d);
        check_eq("R10", "ctrl after reset", d, 32'h0);
        bus_read(1'b1, d);
        check_eq("R10", "count after reset", d, 32'h0);
    endtask

    task automatic t_sources();
        logic [31:0] d;
        run_meas(4'h0, 16'd100, d);
        check_range("R1", "src0 w100", d, 199, 201);
        run_meas(4'h2, 16'd2700, d);
        check_range("R5", "src2 w2700", d, 8099, 8101);
        run_meas(4'h7, 16'd150, d);
        check_range("R1", "src7 w150", d, 599, 601);
    endtask

    task automatic t_hold_and_restore();
        logic [31:0] d, first, saved;
        run_meas(4'h2, 16'd300, first);
        check_range("R1", "src2 w300", first, 899, 901);
        bus_read(1'b0, saved);
        check_eq("R10", "ctrl readback", saved, ctl(0, 1, 0, 4'h2, 16'd300));
        wait_cycles(300);
        bus_read(1'b1, d);
        check_eq("R8", "count held", d, first);
        bus_write(ctl(0, 1, 0, 4'h7, 16'd55));
        wait_cycles(100);
        bus_read(1'b1, d);
        check_eq("R8", "count after we=0 write", d, first);
        bus_read(1'b0, d);
        check_eq("R2", "fields kept on we=0", d, ctl(0, 1, 0, 4'h2, 16'd300));
        bus_write(ctl(0, 0, 1, 4'h0, 16'h0));
        wait_cycles(3);
        bus_read(1'b0, d);
        check_eq("R4", "reset bit readback", d, ctl(0, 0, 1, 4'h2, 16'd300));
        bus_read(1'b1, d);
        check_eq("R4", "count zero in reset", d, 32'h0);
        wait_cycles(20);
        bus_write(saved);
        wait_cycles(600);
        bus_read(1'b1, d);
        check_eq("R6", "no measurement after restore", d, 32'h0);
    endtask

    task automatic t_zero_window();
        logic [31:0] d;
        run_meas(4'h0, 16'd0, d);
        check_eq("R7", "zero window count", d, 32'h0);
    endtask

    task automatic t_enable_low();
        logic [31:0] d;
        clear_counter();
        bus_write(ctl(1, 0, 0, 4'h7, 16'd100));
        wait_cycles(250);
        bus_read(1'b1, d);
        check_eq("R3", "enable low count", d, 32'h0);
        bus_read(1'b0, d);
        check_eq("R2", "fields latched on we=1", d, ctl(0, 0, 0, 4'h7, 16'd100));
    endtask

    task automatic t_unmapped();
        logic [31:0] d;
        run_meas(4'h5, 16'd100, d);
        check_eq("R5", "unmapped source count", d, 32'h0);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        run_meas(4'h7, 16'd5000, d);
        check_eq("R9", "saturated count", d, 32'((1 << CW) - 1));
    endtask

    initial begin
        repeat (200000) @(posedge bus_clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        wait_cycles(5);
        bus_rst_n = 1'b1;
        wait_cycles(3);
        t_reset_state();
        t_sources();
        t_hold_and_restore();
        t_zero_window();
        t_enable_low();
        t_unmapped();
        t_saturate();
        run_meas(4'h0, 16'd400, begin_dummy);
        check_range("R1", "src0 after unmapped", begin_dummy, 799, 801);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    logic [31:0] begin_dummy;

endmodule